// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Bit Streamer

This block lets a serial memory card answer a synchronous reset. When the host raises the card-reset pin while the card is selected and no nonvolatile write is in progress, the block arms. When the pin falls again, it drives a fixed 32-bit identification word onto the shared serial data line, one bit per serial clock. As long as the host keeps clocking, the word repeats. Deselecting the card at any point stops the stream, releases the line and returns the block to standby.

All pins are sampled into the system clock domain through a short synchronizer. Edges are detected there, and the data bit and its output enable leave the block from registers. The identification word is a build-time parameter. Byte 0 sits in the low eight bits. Within a byte, bits go out least significant first by default, and a parameter selects most-significant-first instead.

Top module: `atr_stream_top`

## Requirements
- R1: After the synchronous reset `rst`, `dat_oe` is 0 and `dat_o` is 0. `dat_o` is 0 whenever `dat_oe` is 0.
- R2: With default parameters the stream is the bytes 0x19, 0x01, 0xAA, 0x55 in that order, each sent least significant bit first. Stream bit i therefore equals bit (i mod 8) of byte (i div 8) of that list.
- R3: A rising edge of `card_rst` while `cs_n` is 0 and `wr_busy` is 0 arms the block. While `card_rst` stays high, `dat_oe` stays 0. After `card_rst` falls, `dat_oe` becomes 1 and `dat_o` shows stream bit 0.
- R4: Each falling edge of `ser_clk` during the stream advances the output by exactly one bit. A rising edge of `ser_clk` leaves `dat_o` unchanged.
- R5: After stream bit 31, the next falling edge of `ser_clk` presents bit 0 again. The wrap repeats for as long as clocking continues.
- R6: Driving `cs_n` to 1 while the block is armed or streaming forces `dat_oe` to 0. Later `ser_clk` edges and the return of `cs_n` to 0 do not re-enable it. A new stream needs a new `card_rst` pulse and restarts at bit 0.
- R7: A `card_rst` pulse while `wr_busy` is 1 is ignored, and `dat_oe` stays 0.
- R8: A `card_rst` pulse while `cs_n` is 1 is ignored, and `dat_oe` stays 0 after `cs_n` returns low.
- R9: A `card_rst` rising edge during a stream stops the output, with `dat_oe` at 0 while the pin is high. The stream then restarts at bit 0 when the pin falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| card_rst | input | 1 | Card reset pin, a high pulse requests the answer |
| ser_clk | input | 1 | Serial clock from the host |
| wr_busy | input | 1 | High while the write sequencer runs a nonvolatile cycle |
| dat_o | output | 1 | Serial data bit |
| dat_oe | output | 1 | Output enable for the shared data line |

## Verification
The hardest situation to reach is a deselect or a fresh reset pulse that lands on one specific bit position, and then the wrap from the last bit back to the first. The stimulus starts a stream 32 times. On pass k it clocks exactly k falling edges, checks bit k and then deselects, so every position sees an abort. A separate long run clocks well past three full patterns to exercise the wrap, and another run interrupts a stream with a second reset pulse.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_STREAM = 2'd2
  } atr_state_e;

  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_RST  = 1;
  localparam int unsigned PIN_SCK  = 2;
  localparam int unsigned PIN_BUSY = 3;
  localparam int unsigned PIN_NUM  = 4;
endpackage

// File: rtl/atr_pin_sampler.sv
module atr_pin_sampler #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] IDLE  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] lvl_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= IDLE;
        else     stage_q[s] <= pins_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= IDLE;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign lvl_o = stage_q[STAGES-1];
endmodule

// File: rtl/atr_bit_ptr.sv
module atr_bit_ptr #(
  parameter int unsigned PAT_BITS = 32,
  localparam int unsigned PTR_W   = $clog2(PAT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(PAT_BITS - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i)  ptr_q <= '0;
    else if (step_i)     ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clear_i && ptr_q == LAST) |=> ptr_q == '0);

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> ptr_q == '0);
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_i,
  input  logic       card_rst_i,
  input  logic       sck_i,
  input  logic       busy_i,
  output atr_state_e state_o,
  output logic       clear_o,
  output logic       step_o
);
  atr_state_e state_q, state_d;
  logic rst_prev_q, sck_prev_q;
  logic rst_rise, rst_fall, sck_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_prev_q <= 1'b0;
      sck_prev_q <= 1'b0;
      state_q    <= ST_IDLE;
    end else begin
      rst_prev_q <= card_rst_i;
      sck_prev_q <= sck_i;
      state_q    <= state_d;
    end
  end

  assign rst_rise = card_rst_i & ~rst_prev_q;
  assign rst_fall = ~card_rst_i & rst_prev_q;
  assign sck_fall = ~sck_i & sck_prev_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (rst_rise && !cs_n_i && !busy_i) state_d = ST_ARMED;
      ST_ARMED:  if (cs_n_i)        state_d = ST_IDLE;
                 else if (rst_fall) state_d = ST_STREAM;
      ST_STREAM: if (cs_n_i)        state_d = ST_IDLE;
                 else if (rst_rise) state_d = ST_ARMED;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign clear_o = (state_q == ST_ARMED) && !cs_n_i && rst_fall;
  assign step_o  = (state_q == ST_STREAM) && !cs_n_i && !rst_rise && sck_fall;
  assign state_o = state_q;

  assert_busy_block_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && busy_i) |=> state_q == ST_IDLE);

  assert_desel_block_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && cs_n_i) |=> state_q == ST_IDLE);

  assert_rearm_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STREAM && !cs_n_i && rst_rise) |=> state_q == ST_ARMED);
endmodule

// File: rtl/atr_stream_top.sv
module atr_stream_top
  import atr_pkg::*;
#(
  parameter int unsigned  PAT_BITS  = 32,
  parameter logic [PAT_BITS-1:0] PATTERN = 32'h55AA_0119,
  parameter bit           LSB_FIRST = 1'b1,
  parameter int unsigned  SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic card_rst,
  input  logic ser_clk,
  input  logic wr_busy,
  output logic dat_o,
  output logic dat_oe
);
  localparam int unsigned PTR_W     = $clog2(PAT_BITS);
  localparam int unsigned FIRST_IDX = LSB_FIRST ? 0 : 7;
  localparam logic [PIN_NUM-1:0] PIN_IDLE = PIN_NUM'(1) << PIN_CS;

  logic [PIN_NUM-1:0] pins_raw, pins_lvl;
  atr_state_e         state;
  logic               clear, step;
  logic [PTR_W-1:0]   ptr, idx;
  logic               oe_q, dat_q;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n;
    pins_raw[PIN_RST]  = card_rst;
    pins_raw[PIN_SCK]  = ser_clk;
    pins_raw[PIN_BUSY] = wr_busy;
  end

  atr_pin_sampler #(
    .W(PIN_NUM), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)
  ) sampler_i (
    .clk(clk), .rst(rst), .pins_i(pins_raw), .lvl_o(pins_lvl)
  );

  atr_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .cs_n_i(pins_lvl[PIN_CS]), .card_rst_i(pins_lvl[PIN_RST]),
    .sck_i(pins_lvl[PIN_SCK]), .busy_i(pins_lvl[PIN_BUSY]),
    .state_o(state), .clear_o(clear), .step_o(step)
  );

  atr_bit_ptr #(.PAT_BITS(PAT_BITS)) ptr_i (
    .clk(clk), .rst(rst), .clear_i(clear), .step_i(step), .ptr_o(ptr)
  );

  if (LSB_FIRST) begin : g_lsb_first
    assign idx = ptr;
  end else begin : g_msb_first
    assign idx = {ptr[PTR_W-1:3], ~ptr[2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      oe_q  <= (state == ST_STREAM);
      dat_q <= (state == ST_STREAM) & PATTERN[idx];
    end
  end

  assign dat_oe = oe_q;
  assign dat_o  = dat_q;

  assert_desel_release_R6: assert property (@(posedge clk) disable iff (rst)
    pins_lvl[PIN_CS] |=> ##1 !dat_oe);

  assert_start_bit_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_oe) |-> dat_o == PATTERN[FIRST_IDX]);

  assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
    (dat_oe && $past(dat_oe) && !$past(step, 2) && !$past(clear, 2))
      |-> $stable(dat_o));

  assert_quiet_line_R1: assert property (@(posedge clk) disable iff (rst)
    (state != ST_STREAM) |=> (!dat_oe && !dat_o));
endmodule

// File: tb/atr_stream_top_tb.sv
`timescale 1ns/1ps
module atr_stream_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, card_rst = 1'b0, ser_clk = 1'b0, wr_busy = 1'b0;
  logic dat_o, dat_oe;
  int   checks = 0;
  int   fails  = 0;

  localparam logic [7:0] BYTES [4] = '{8'h19, 8'h01, 8'hAA, 8'h55};

  always #2.5 clk = ~clk;

  atr_stream_top dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .card_rst(card_rst),
    .ser_clk(ser_clk), .wr_busy(wr_busy), .dat_o(dat_o), .dat_oe(dat_oe)
  );

  function automatic logic exp_bit(int i);
    int j = i % 32;
    return BYTES[j / 8][j % 8];
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic exp_oe, logic exp_d);
    checks++;
    if (dat_oe !== exp_oe || dat_o !== exp_d) begin
      fails++;
      $display("FAIL %s: oe=%0b dat=%0b expected oe=%0b dat=%0b",
               req, dat_oe, dat_o, exp_oe, exp_d);
    end
  endtask

  task automatic start_stream(string req);
    card_rst = 1'b1; step(6);
    check(req, 1'b0, 1'b0);
    card_rst = 1'b0; step(6);
  endtask

  task automatic sck_pulse();
    ser_clk = 1'b1; step(6);
    ser_clk = 1'b0; step(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0; step(4);
    check("R1 reset state", 1'b0, 1'b0);

    cs_n = 1'b0; step(6);
    start_stream("R3 armed holds line off");
    check("R3 first bit", 1'b1, exp_bit(0));
    for (int i = 1; i < 32; i++) begin
      ser_clk = 1'b1; step(6);
      check("R4 rising edge holds", 1'b1, exp_bit(i - 1));
      ser_clk = 1'b0; step(6);
      check("R2 pattern bit", 1'b1, exp_bit(i));
    end
    for (int i = 32; i < 110; i++) begin
      sck_pulse();
      check("R5 wrap repeat", 1'b1, exp_bit(i));
    end

    // Abort at every bit position.
    for (int k = 0; k < 32; k++) begin
      cs_n = 1'b1; step(6);
      cs_n = 1'b0; step(6);
      start_stream("R3 armed holds line off");
      for (int j = 0; j < k; j++) sck_pulse();
      check("R4 bit at position", 1'b1, exp_bit(k));
      cs_n = 1'b1; step(6);
      check("R6 deselect releases", 1'b0, 1'b0);
      sck_pulse();
      check("R6 clocks while deselected", 1'b0, 1'b0);
    end
    cs_n = 1'b0; step(6);
    sck_pulse();
    check("R6 reselect stays off", 1'b0, 1'b0);
    start_stream("R6 new pulse armed");
    check("R6 restart at bit 0", 1'b1, exp_bit(0));

    // Re-pulse during a stream.
    for (int j = 0; j < 5; j++) sck_pulse();
    check("R9 before re-pulse", 1'b1, exp_bit(5));
    start_stream("R9 re-pulse stops output");
    check("R9 restart at bit 0", 1'b1, exp_bit(0));
    sck_pulse();
    check("R9 continues", 1'b1, exp_bit(1));

    // Busy blocks a pulse.
    cs_n = 1'b1; step(6);
    cs_n = 1'b0; wr_busy = 1'b1; step(6);
    card_rst = 1'b1; step(6);
    card_rst = 1'b0; step(6);
    check("R7 pulse while busy", 1'b0, 1'b0);
    wr_busy = 1'b0; step(6);
    sck_pulse();
    check("R7 still idle after busy", 1'b0, 1'b0);

    // Deselected pulse.
    cs_n = 1'b1; step(6);
    card_rst = 1'b1; step(6);
    card_rst = 1'b0; step(6);
    cs_n = 1'b0; step(6);
    sck_pulse();
    check("R8 pulse while deselected", 1'b0, 1'b0);

    // Deselect while armed.
    card_rst = 1'b1; step(6);
    cs_n = 1'b1; step(6);
    card_rst = 1'b0; step(6);
    check("R6 abort while armed", 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule